// File: doc/BRIEF.md
# Register Rename Stage with Checkpoint Recovery

This block renames a group of decoded instructions in one cycle. Each instruction slot has two logical source registers and one logical destination with its own valid bit. Sources are looked up in a live map from logical to physical register numbers. Every valid destination takes a fresh physical register from a free pool, and the new mapping is installed in the live map at the end of the cycle. A comparator network works in parallel with the map read. It replaces a source's looked-up value with the new physical register of the youngest earlier slot in the same group that writes the same logical register.

The rename result is combinational and is presented in the same cycle as the group. `out_valid` marks the cycles in which the group is accepted. A group may ask for a checkpoint. The snapshot then holds the map after that group's own writes. A later restore request brings back both the live map and the free pool in a single cycle, and drops that checkpoint and all younger ones. A release port returns one physical register per cycle to the pool, for use by the commit side.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register l maps to physical register l. Physical registers NLOG to NPHYS-1 are free, and no checkpoint is held.
- R2: A source with no earlier producer in its group gets the physical register held in the live map for its logical register.
- R3: A source whose logical register matches the valid destination of one or more earlier slots in the same group gets the new physical register of the latest such slot. Slots whose destination valid bit is 0 never act as producers.
- R4: Valid destinations receive the lowest-numbered free physical registers in ascending slot order, with slot 0 getting the lowest. A slot whose destination valid bit is 0 reports physical register 0.
- R5: An accepted group installs its mappings in the live map. When several slots write the same logical register, the highest slot's mapping is kept.
- R6: When fewer physical registers are free than the group has valid destinations, `stall` is 1 and neither the map nor the free pool changes.
- R7: An accepted group with `in_ckpt_req` set stores the map as it stands after that group's writes. The snapshot goes into slot number equal to the count of live checkpoints, which is reported on `out_ckpt_id`, and the count then rises by one.
- R8: A checkpoint request while NCKPT checkpoints are already live stalls the group.
- R9: `restore_req` with `restore_id` below the live count replaces the live map with that snapshot in one cycle. It returns every register allocated after the snapshot to the free pool and sets the live count to `restore_id`. A restore with `restore_id` at or above the count changes nothing. Any group presented while `restore_req` is 1 is stalled.
- R10: `rel_vld` returns physical register `rel_preg` to the free pool from the next cycle on.
- R11: `stall` is only asserted while `in_valid` is 1, and `out_valid` is 1 exactly when `in_valid` is 1 and `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A group is presented |
| in_src0 | input | W*LW | First logical source per slot, slot i at bits i*LW |
| in_src1 | input | W*LW | Second logical source per slot |
| in_dst | input | W*LW | Logical destination per slot |
| in_dst_vld | input | W | Destination valid per slot |
| in_ckpt_req | input | 1 | Take a checkpoint after this group |
| restore_req | input | 1 | Restore a checkpoint |
| restore_id | input | CKW | Checkpoint to restore |
| rel_vld | input | 1 | Release a physical register |
| rel_preg | input | PW | Physical register to release |
| out_valid | output | 1 | Group accepted this cycle |
| out_psrc0 | output | W*PW | Renamed first source per slot |
| out_psrc1 | output | W*PW | Renamed second source per slot |
| out_pdst | output | W*PW | New physical destination per slot |
| out_ckpt_id | output | CKW | Checkpoint slot taken by this group |
| stall | output | 1 | Group cannot be accepted this cycle |

## Verification
On every cycle the assertions check the stall conditions: a restore in flight, full checkpoint storage, and too few free registers. They also check that each new destination comes from the free pool and is unique within the group, and that the checkpoint count moves by exactly one on a push and falls to the restored index on a restore. Only the bench scenarios can show the mapping values themselves. This covers the bypass from the youngest earlier producer, the youngest-wins update on a duplicated destination, and that a snapshot taken after a group's own writes returns a map that is correct entry by entry. It also covers the exact registers handed back by a restore or a release, which the bench sees in later allocations.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_WIDTH  = 4;
  localparam int DEF_NLOG   = 16;
  localparam int DEF_NPHYS  = 64;
  localparam int DEF_NCKPT  = 4;
endpackage

// File: rtl/rn_depcheck.sv
module rn_depcheck #(
  parameter int W  = 4,
  parameter int LW = 4,
  parameter int PW = 6
) (
  input  logic [2*W*LW-1:0] src_log,
  input  logic [2*W*PW-1:0] tbl_phys,
  input  logic [W*LW-1:0]   dst_log,
  input  logic [W-1:0]      dst_vld,
  input  logic [W*PW-1:0]   new_phys,
  output logic [2*W*PW-1:0] src_phys
);
  // Operand n belongs to slot n/2; only strictly earlier slots may produce.
  for (genvar n = 0; n < 2*W; n++) begin : g_opnd
    localparam int SLOT = n / 2;
    always_comb begin
      src_phys[n*PW +: PW] = tbl_phys[n*PW +: PW];
      for (int j = 0; j < SLOT; j++) begin
        if (dst_vld[j] && (dst_log[j*LW +: LW] == src_log[n*LW +: LW]))
          src_phys[n*PW +: PW] = new_phys[j*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int W     = 4,
  parameter int NLOG  = 16,
  parameter int NPHYS = 64,
  parameter int NCKPT = 4,
  localparam int PW   = $clog2(NPHYS),
  localparam int CKW  = $clog2(NCKPT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      dst_vld,
  input  logic              alloc_en,
  input  logic              rel_vld,
  input  logic [PW-1:0]     rel_preg,
  input  logic              ckpt_take,
  input  logic [CKW-1:0]    ckpt_slot,
  input  logic              restore_en,
  input  logic [CKW-1:0]    restore_slot,
  output logic [W*PW-1:0]   alloc_preg,
  output logic              alloc_ok,
  output logic [NPHYS-1:0]  free_vec
);
  logic [NPHYS-1:0] free_q, free_d;
  logic [NPHYS-1:0] since_q [NCKPT];
  logic [NPHYS-1:0] since_d [NCKPT];
  logic [PW-1:0]    pick [W];
  logic [W-1:0]     found;
  logic [NPHYS-1:0] avail;
  logic [NPHYS-1:0] used;

  // Up to W lowest free registers, each search masking the previous pick.
  always_comb begin
    avail = free_q;
    for (int k = 0; k < W; k++) begin
      found[k] = 1'b0;
      pick[k]  = '0;
      for (int p = NPHYS-1; p >= 0; p--) begin
        if (avail[p]) begin
          found[k] = 1'b1;
          pick[k]  = PW'(p);
        end
      end
      if (found[k]) avail[pick[k]] = 1'b0;
    end
  end

  // Hand picks out by rank among valid destinations.
  always_comb begin
    int rank;
    rank       = 0;
    alloc_ok   = 1'b1;
    used       = '0;
    alloc_preg = '0;
    for (int i = 0; i < W; i++) begin
      if (dst_vld[i]) begin
        for (int k = 0; k < W; k++) begin
          if (k == rank) begin
            alloc_ok = alloc_ok & found[k];
            alloc_preg[i*PW +: PW] = pick[k];
            if (found[k]) used[pick[k]] = 1'b1;
          end
        end
        rank = rank + 1;
      end
    end
  end

  always_comb begin
    free_d = free_q;
    if (alloc_en)   free_d = free_d & ~used;
    if (restore_en) free_d = free_d | since_q[restore_slot];
    if (rel_vld)    free_d[rel_preg] = 1'b1;
    for (int s = 0; s < NCKPT; s++) begin
      since_d[s] = alloc_en ? (since_q[s] | used) : since_q[s];
      if (ckpt_take && (ckpt_slot == CKW'(s))) since_d[s] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPHYS; p++) free_q[p] <= (p >= NLOG);
      for (int s = 0; s < NCKPT; s++) since_q[s] <= '0;
    end else begin
      free_q <= free_d;
      for (int s = 0; s < NCKPT; s++) since_q[s] <= since_d[s];
    end
  end

  assign free_vec = free_q;
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int W     = 4,
  parameter int NLOG  = 16,
  parameter int NPHYS = 64,
  parameter int NCKPT = 4,
  localparam int LW   = $clog2(NLOG),
  localparam int PW   = $clog2(NPHYS),
  localparam int CKW  = $clog2(NCKPT),
  localparam int CNW  = $clog2(NCKPT+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      wr_en,
  input  logic [W*LW-1:0]   wr_log,
  input  logic [W*PW-1:0]   wr_phys,
  input  logic              ckpt_take,
  input  logic              restore_en,
  input  logic [CKW-1:0]    restore_slot,
  input  logic [2*W*LW-1:0] rd_log,
  output logic [2*W*PW-1:0] rd_phys,
  output logic [CNW-1:0]    ckpt_cnt
);
  logic [PW-1:0]  map_q [NLOG];
  logic [PW-1:0]  map_d [NLOG];
  logic [PW-1:0]  snap_q [NCKPT][NLOG];
  logic [CNW-1:0] cnt_q, cnt_d;
  logic [CKW-1:0] push_slot;

  assign push_slot = cnt_q[CKW-1:0];

  for (genvar n = 0; n < 2*W; n++) begin : g_rd
    assign rd_phys[n*PW +: PW] = map_q[rd_log[n*LW +: LW]];
  end

  // Ascending slot order lets the youngest writer of a register win.
  always_comb begin
    for (int l = 0; l < NLOG; l++) map_d[l] = map_q[l];
    if (restore_en) begin
      for (int l = 0; l < NLOG; l++) map_d[l] = snap_q[restore_slot][l];
    end else begin
      for (int i = 0; i < W; i++)
        if (wr_en[i]) map_d[wr_log[i*LW +: LW]] = wr_phys[i*PW +: PW];
    end
    cnt_d = cnt_q;
    if (restore_en)     cnt_d = CNW'(restore_slot);
    else if (ckpt_take) cnt_d = cnt_q + CNW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLOG; l++) map_q[l] <= PW'(l);
      cnt_q <= '0;
    end else begin
      for (int l = 0; l < NLOG; l++) map_q[l] <= map_d[l];
      cnt_q <= cnt_d;
    end
  end

  // Snapshot storage is data only; the live count guards it.
  always_ff @(posedge clk) begin
    if (ckpt_take) begin
      for (int l = 0; l < NLOG; l++) snap_q[push_slot][l] <= map_d[l];
    end
  end

  assign ckpt_cnt = cnt_q;
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int W     = rn_pkg::DEF_WIDTH,
  parameter int NLOG  = rn_pkg::DEF_NLOG,
  parameter int NPHYS = rn_pkg::DEF_NPHYS,
  parameter int NCKPT = rn_pkg::DEF_NCKPT,
  localparam int LW   = $clog2(NLOG),
  localparam int PW   = $clog2(NPHYS),
  localparam int CKW  = $clog2(NCKPT),
  localparam int CNW  = $clog2(NCKPT+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W*LW-1:0] in_src0,
  input  logic [W*LW-1:0] in_src1,
  input  logic [W*LW-1:0] in_dst,
  input  logic [W-1:0]    in_dst_vld,
  input  logic            in_ckpt_req,
  input  logic            restore_req,
  input  logic [CKW-1:0]  restore_id,
  input  logic            rel_vld,
  input  logic [PW-1:0]   rel_preg,
  output logic            out_valid,
  output logic [W*PW-1:0] out_psrc0,
  output logic [W*PW-1:0] out_psrc1,
  output logic [W*PW-1:0] out_pdst,
  output logic [CKW-1:0]  out_ckpt_id,
  output logic            stall
);
  logic [2*W*LW-1:0] rd_log;
  logic [2*W*PW-1:0] tbl_phys;
  logic [2*W*PW-1:0] src_phys;
  logic [W*PW-1:0]   alloc_preg;
  logic [NPHYS-1:0]  free_vec;
  logic [CNW-1:0]    ckpt_cnt;
  logic              alloc_ok, ckpt_full, restore_ok, fire, ckpt_take;
  logic [W-1:0]      wr_en;

  for (genvar i = 0; i < W; i++) begin : g_slot
    assign rd_log[(2*i)*LW   +: LW] = in_src0[i*LW +: LW];
    assign rd_log[(2*i+1)*LW +: LW] = in_src1[i*LW +: LW];
    assign out_psrc0[i*PW +: PW]    = src_phys[(2*i)*PW   +: PW];
    assign out_psrc1[i*PW +: PW]    = src_phys[(2*i+1)*PW +: PW];
    assign out_pdst[i*PW +: PW]     = in_dst_vld[i] ? alloc_preg[i*PW +: PW] : '0;
  end

  assign ckpt_full   = (ckpt_cnt == CNW'(NCKPT));
  assign restore_ok  = restore_req && (CNW'(restore_id) < ckpt_cnt);
  assign stall       = in_valid && (restore_req || !alloc_ok || (in_ckpt_req && ckpt_full));
  assign fire        = in_valid && !stall;
  assign ckpt_take   = fire && in_ckpt_req;
  assign wr_en       = fire ? in_dst_vld : '0;
  assign out_valid   = fire;
  assign out_ckpt_id = ckpt_cnt[CKW-1:0];

  rn_maptable #(.W(W), .NLOG(NLOG), .NPHYS(NPHYS), .NCKPT(NCKPT)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_log(in_dst), .wr_phys(alloc_preg),
    .ckpt_take(ckpt_take), .restore_en(restore_ok), .restore_slot(restore_id),
    .rd_log(rd_log), .rd_phys(tbl_phys), .ckpt_cnt(ckpt_cnt)
  );

  rn_depcheck #(.W(W), .LW(LW), .PW(PW)) u_dep (
    .src_log(rd_log), .tbl_phys(tbl_phys), .dst_log(in_dst), .dst_vld(in_dst_vld),
    .new_phys(alloc_preg), .src_phys(src_phys)
  );

  rn_freelist #(.W(W), .NLOG(NLOG), .NPHYS(NPHYS), .NCKPT(NCKPT)) u_free (
    .clk(clk), .rst_n(rst_n), .dst_vld(in_dst_vld), .alloc_en(fire),
    .rel_vld(rel_vld), .rel_preg(rel_preg), .ckpt_take(ckpt_take),
    .ckpt_slot(ckpt_cnt[CKW-1:0]), .restore_en(restore_ok), .restore_slot(restore_id),
    .alloc_preg(alloc_preg), .alloc_ok(alloc_ok), .free_vec(free_vec)
  );
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int W     = 4,
  parameter int NPHYS = 64,
  parameter int NCKPT = 4,
  localparam int PW   = $clog2(NPHYS),
  localparam int CKW  = $clog2(NCKPT),
  localparam int CNW  = $clog2(NCKPT+1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [W-1:0]    in_dst_vld,
  input logic            in_ckpt_req,
  input logic            restore_req,
  input logic [CKW-1:0]  restore_id,
  input logic            out_valid,
  input logic            stall,
  input logic [W*PW-1:0] out_pdst,
  input logic [CNW-1:0]  ckpt_cnt,
  input logic [NPHYS-1:0] free_vec
);
  logic from_pool, distinct;

  always_comb begin
    from_pool = 1'b1;
    distinct  = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (in_dst_vld[i]) begin
        if (!free_vec[out_pdst[i*PW +: PW]]) from_pool = 1'b0;
        for (int j = 0; j < i; j++)
          if (in_dst_vld[j] && (out_pdst[j*PW +: PW] == out_pdst[i*PW +: PW])) distinct = 1'b0;
      end
    end
  end

  assert_restore_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && restore_req) |-> stall);
  assert_restore_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && (CNW'(restore_id) < ckpt_cnt)) |=> (ckpt_cnt == $past(CNW'(restore_id))));
  assert_full_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ckpt_req && (ckpt_cnt == CNW'(NCKPT))) |-> stall);
  assert_ckpt_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_ckpt_req) |=> (ckpt_cnt == $past(ckpt_cnt) + CNW'(1)));
  assert_ckpt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_cnt <= CNW'(NCKPT));
  assert_short_pool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($countones(free_vec) < $countones(in_dst_vld))) |-> stall);
  assert_alloc_pool_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> from_pool);
  assert_alloc_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> distinct);
  assert_stall_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!stall && !out_valid));
endmodule

bind rename_unit rn_checker #(.W(W), .NPHYS(NPHYS), .NCKPT(NCKPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_vld(in_dst_vld),
  .in_ckpt_req(in_ckpt_req), .restore_req(restore_req), .restore_id(restore_id),
  .out_valid(out_valid), .stall(stall), .out_pdst(out_pdst),
  .ckpt_cnt(ckpt_cnt), .free_vec(free_vec)
);

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
  localparam int W = 4, NLOG = 8, NPHYS = 20, NCKPT = 2;
  localparam int LW = 3, PW = 5, CKW = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ckpt_req, restore_req, rel_vld;
  logic [W*LW-1:0] in_src0, in_src1, in_dst;
  logic [W-1:0] in_dst_vld;
  logic [CKW-1:0] restore_id;
  logic [PW-1:0] rel_preg;
  logic out_valid, stall;
  logic [W*PW-1:0] out_psrc0, out_psrc1, out_pdst;
  logic [CKW-1:0] out_ckpt_id;

  rename_unit #(.W(W), .NLOG(NLOG), .NPHYS(NPHYS), .NCKPT(NCKPT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src0(in_src0), .in_src1(in_src1),
    .in_dst(in_dst), .in_dst_vld(in_dst_vld), .in_ckpt_req(in_ckpt_req),
    .restore_req(restore_req), .restore_id(restore_id), .rel_vld(rel_vld), .rel_preg(rel_preg),
    .out_valid(out_valid), .out_psrc0(out_psrc0), .out_psrc1(out_psrc1), .out_pdst(out_pdst),
    .out_ckpt_id(out_ckpt_id), .stall(stall)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int s0[W], s1[W], d[W];
  bit dv[W];
  bit iv, ck, rs, rv;
  int rid, rp;
  int mtab[NLOG];
  bit mfree[NPHYS];
  int msnap[NCKPT][NLOG];
  bit mmask[NCKPT][NPHYS];
  int mcnt;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NLOG; l++) mtab[l] = l;
    for (int p = 0; p < NPHYS; p++) mfree[p] = (p >= NLOG);
    for (int s = 0; s < NCKPT; s++) for (int p = 0; p < NPHYS; p++) mmask[s][p] = 0;
    mcnt = 0;
  endtask

  task automatic quiet();
    iv = 0; ck = 0; rs = 0; rv = 0; rid = 0; rp = 0;
    for (int i = 0; i < W; i++) begin s0[i] = 0; s1[i] = 0; d[i] = 0; dv[i] = 0; end
  endtask

  task automatic probe_set();
    quiet();
    iv = 1;
    for (int i = 0; i < W; i++) begin s0[i] = i; s1[i] = i + W; end
  endtask

  // One cycle: drive, compare against the model, advance the model.
  task automatic run(string stag, string dtag);
    int need, fcnt, ep[W], v;
    bit exp_stall, fire, byp;
    bit tfree[NPHYS];
    @(negedge clk);
    in_valid = iv; in_ckpt_req = ck; restore_req = rs; rel_vld = rv;
    restore_id = CKW'(rid); rel_preg = PW'(rp);
    for (int i = 0; i < W; i++) begin
      in_src0[i*LW +: LW] = LW'(s0[i]); in_src1[i*LW +: LW] = LW'(s1[i]);
      in_dst[i*LW +: LW] = LW'(d[i]); in_dst_vld[i] = dv[i];
    end
    #1;
    need = 0; fcnt = 0;
    for (int i = 0; i < W; i++) need += dv[i];
    for (int p = 0; p < NPHYS; p++) fcnt += mfree[p];
    exp_stall = iv && (rs || fcnt < need || (ck && mcnt == NCKPT));
    fire = iv && !exp_stall;
    chk(stag, int'(stall), int'(exp_stall));
    chk("R11", int'(out_valid), int'(fire));
    tfree = mfree;
    if (fire) begin
      for (int i = 0; i < W; i++) begin
        ep[i] = 0;
        if (dv[i]) begin
          for (int p = NPHYS-1; p >= 0; p--) if (tfree[p]) ep[i] = p;
          tfree[ep[i]] = 0;
        end
        chk(dtag == "" ? "R4" : dtag, int'(out_pdst[i*PW +: PW]), ep[i]);
      end
      for (int i = 0; i < W; i++) begin
        for (int k = 0; k < 2; k++) begin
          int src = (k == 0) ? s0[i] : s1[i];
          v = mtab[src]; byp = 0;
          for (int j = 0; j < i; j++) if (dv[j] && d[j] == src) begin v = ep[j]; byp = 1; end
          chk(dtag != "" ? dtag : (byp ? "R3" : "R2"),
              int'(k == 0 ? out_psrc0[i*PW +: PW] : out_psrc1[i*PW +: PW]), v);
        end
      end
      if (ck) chk("R7", int'(out_ckpt_id), mcnt);
      for (int i = 0; i < W; i++) if (dv[i]) mtab[d[i]] = ep[i];
      mfree = tfree;
      for (int s = 0; s < NCKPT; s++)
        for (int i = 0; i < W; i++) if (dv[i]) mmask[s][ep[i]] = 1;
      if (ck) begin
        msnap[mcnt] = mtab;
        for (int p = 0; p < NPHYS; p++) mmask[mcnt][p] = 0;
        mcnt++;
      end
    end
    if (rs && rid < mcnt) begin
      mtab = msnap[rid];
      for (int p = 0; p < NPHYS; p++) if (mmask[rid][p]) mfree[p] = 1;
      mcnt = rid;
    end
    if (rv) mfree[rp] = 1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    in_valid = 0; in_ckpt_req = 0; restore_req = 0; rel_vld = 0;
    in_src0 = '0; in_src1 = '0; in_dst = '0; in_dst_vld = '0; restore_id = '0; rel_preg = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", int'(stall), 0);
    chk("R1", int'(out_valid), 0);
    rst_n = 1;

    // R1: identity map read back
    probe_set(); run("R1", "R1");
    // R3/R5: producers, duplicate destination, youngest wins
    quiet(); iv = 1;
    s0 = '{0, 1, 1, 2}; s1 = '{5, 1, 3, 1}; d = '{1, 2, 1, 3}; dv = '{1, 1, 1, 1};
    run("R6", "");
    probe_set(); run("R6", "R5");
    // R3: slot without a valid destination is not a producer
    quiet(); iv = 1;
    s0 = '{0, 4, 4, 6}; s1 = '{0, 0, 7, 7}; d = '{4, 7, 0, 0}; dv = '{0, 1, 0, 0};
    run("R6", "");
    // R6: drain the pool, then a short group stalls and changes nothing
    for (int n = 0; n < 4; n++) begin
      quiet(); iv = 1;
      for (int i = 0; i < W; i++) begin d[i] = (n + i) % NLOG; dv[i] = 1; s0[i] = i; s1[i] = 7 - i; end
      run("R6", "");
    end
    quiet(); iv = 1; dv[0] = 1; d[0] = 5; run("R6", "");
    probe_set(); run("R6", "R6");
    // R10: released register is handed out next
    quiet(); rv = 1; rp = 9; run("R10", "");
    quiet(); iv = 1; dv[2] = 1; d[2] = 6; run("R10", "R10");
    for (int p = 8; p < 16; p++) begin quiet(); rv = 1; rp = p; run("R10", ""); end
    // R7/R8: fill the checkpoint slots
    quiet(); iv = 1; ck = 1; dv[0] = 1; d[0] = 2; run("R7", "");
    quiet(); iv = 1; ck = 1; dv[1] = 1; d[1] = 3; dv[3] = 1; d[3] = 2; run("R7", "");
    quiet(); iv = 1; ck = 1; dv[0] = 1; d[0] = 4; run("R8", "");
    quiet(); iv = 1; dv[0] = 1; d[0] = 4; dv[1] = 1; d[1] = 0; run("R8", "");
    // R9: restores, stall during restore, out-of-range restore ignored
    quiet(); iv = 1; rs = 1; rid = 1; dv[0] = 1; run("R9", "");
    probe_set(); run("R9", "R9");
    quiet(); rs = 1; rid = 0; run("R9", "");
    probe_set(); run("R9", "R9");
    quiet(); rs = 1; rid = 1; run("R9", "");
    probe_set(); run("R9", "R9");
    quiet(); iv = 1; for (int i = 0; i < W; i++) begin dv[i] = 1; d[i] = i; end run("R9", "R9");

    // Broad sweep of random groups, checkpoints, restores and releases
    for (int n = 0; n < 6000; n++) begin
      quiet();
      iv = ($urandom % 8) != 0;
      ck = ($urandom % 4) == 0;
      rs = ($urandom % 12) == 0;
      rid = $urandom % NCKPT;
      for (int i = 0; i < W; i++) begin
        s0[i] = $urandom % NLOG; s1[i] = $urandom % NLOG;
        d[i] = $urandom % NLOG; dv[i] = ($urandom % 3) != 0;
      end
      rp = $urandom % NPHYS;
      rv = !mfree[rp] && (($urandom % 2) == 0);
      run("R6", "");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule